// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block drives the control strobes and the 8-bit I/O lines of a raw NAND flash device for the opening of a page read. On a one-cycle start pulse it captures a command byte, an erase-block number, a page index inside that block and a column offset. It then waits for the device ready line, latches the command byte and the address bytes one strobe at a time, releases both latch enables, waits for ready once more and raises a one-cycle done pulse. The data transfer that follows belongs to other logic.

Three elaboration parameters choose the device flavour. The first selects small-page (512-byte) or large-page (2 KiB) addressing. The second adds one further row byte for larger devices. The third declares a 16-bit data bus. In large-page mode the block closes the address phase with a read-confirm command. It also turns a spare-area read request into an ordinary read of the column past the end of the page. With a 16-bit bus it converts the column to a word address.

The row address is formed as block number times pages per block plus the page index. Each latched byte costs two clock cycles: one with the write strobe low and one with it high while the byte is held.

Top module: `nand_cmd_seq`

## Requirements
- R1: After a start pulse, no write strobe is issued while `flash_rdy` is low. The first strobe follows the first cycle in which ready is seen high.
- R2: The row address equals `block_in` × PAGES_PER_BLOCK + `page_in` (default 64 pages per block). Row bits are sent least significant byte first.
- R3: A command byte is latched with `flash_cle`=1 and `flash_ale`=0. An address byte is latched with `flash_ale`=1 and `flash_cle`=0. The two are never high together.
- R4: In small-page mode the bytes are: the command, then col[7:0], then row[7:0], then row[15:8]. With the extra cycle enabled, a fifth byte {4'h0, row[19:16]} follows.
- R5: In large-page mode the bytes are: the command, then col[7:0], then col[15:8], then row[7:0], then row[15:8]. With the extra cycle enabled, {4'h0, row[19:16]} comes next. The frame ends with the command 8'h30.
- R6: In large-page mode a command of 8'h50 is sent as 8'h00, and 2048 is added to the column. Other commands and small-page mode pass unchanged.
- R7: In large-page mode with a 16-bit bus, the column, after any R6 adjustment, is shifted right by one bit before it is split into bytes.
- R8: Each byte is latched by `flash_we_n` low for exactly one cycle. `flash_io`, `flash_cle` and `flash_ale` take the byte in that cycle and keep it through the following cycle.
- R9: After the last byte, `flash_cle` and `flash_ale` both go low. `done` pulses for one cycle only after `flash_rdy` is seen high again. A start pulse during a sequence is ignored.
- R10: In reset and idle, `flash_we_n`=1, `flash_cle`=0, `flash_ale`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request, taken only when idle |
| cmd_in | input | 8 | Command byte |
| block_in | input | BLOCK_W (14) | Erase-block number |
| page_in | input | log2(PAGES_PER_BLOCK) (6) | Page index within the block |
| col_in | input | COL_W (12) | Column byte offset |
| flash_rdy | input | 1 | Device ready (1) / busy (0) |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_io | output | 8 | Byte driven to the device |
| done | output | 1 | One-cycle pulse when the sequence is complete |

## Verification
The hardest situations to reach from the ports are a device that is still busy exactly when the first byte would go out, and a second start pulse arriving in the middle of a frame. A device model in the bench holds ready low for a random number of cycles after each start and again after the address phase. It also records every strobe together with the state of the latch enables. A directed operation pulses start again part-way through a frame with different operands, and the recorded frame must still match the first request. Four parameter sets run side by side on the same random requests: small and large page, each with and without the extra row byte, one of them with a 16-bit bus. This covers every frame layout, the spare-read rewrite and the word-address shift.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int          MAX_SLOTS  = 7;
  localparam int          ROW_BITS   = 24;
  localparam logic [7:0]  OP_READ    = 8'h00;
  localparam logic [7:0]  OP_SPARE   = 8'h50;
  localparam logic [7:0]  OP_CONFIRM = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PRE,
    ST_STROBE,
    ST_HOLD,
    ST_WAIT_POST
  } seq_state_t;

  // One latched byte: command (CLE) or address (ALE)
  typedef struct packed {
    logic       is_cmd;
    logic [7:0] val;
  } latch_slot_t;

endpackage

// File: rtl/nand_row_calc.sv
module nand_row_calc #(
  parameter int BLOCK_W         = 14,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int PAGE_W          = $clog2(PAGES_PER_BLOCK)
) (
  input  logic [BLOCK_W-1:0]                 blk,
  input  logic [PAGE_W-1:0]                  page,
  output logic [nand_seq_pkg::ROW_BITS-1:0]  row
);
  import nand_seq_pkg::*;

  // R2: row = block * pages-per-block + page
  assign row = ROW_BITS'(blk) * ROW_BITS'(PAGES_PER_BLOCK) + ROW_BITS'(page);

endmodule

// File: rtl/nand_frame_build.sv
module nand_frame_build
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter bit EXTRA_ADDR = 1'b1,
  parameter bit BUS16      = 1'b0,
  parameter int COL_W      = 12
) (
  input  logic [7:0]                         cmd,
  input  logic [COL_W-1:0]                   col,
  input  logic [ROW_BITS-1:0]                row,
  output latch_slot_t [MAX_SLOTS-1:0]        slots,
  output logic [2:0]                         count
);

  localparam int PAGE_BYTES = LARGE_PAGE ? 2048 : 512;
  localparam int BASE_CNT   = LARGE_PAGE ? 6 : 4;
  localparam logic [2:0] N_SLOTS = 3'(BASE_CNT + (EXTRA_ADDR ? 1 : 0));

  logic [7:0] extra_row;
  logic       unused_bits;

  assign count       = N_SLOTS;
  assign extra_row   = {4'h0, row[19:16]};
  assign unused_bits = ^{row, col};

  generate
    if (LARGE_PAGE) begin : g_large
      logic [7:0]  eff_cmd;
      logic [15:0] eff_col;

      always_comb begin
        eff_cmd = cmd;
        eff_col = 16'(col);
        // R6: spare-area read becomes plain read past the page end
        if (cmd == OP_SPARE) begin
          eff_cmd = OP_READ;
          eff_col = 16'(col) + 16'(PAGE_BYTES);
        end
        // R7: word addressing on a 16-bit bus
        if (BUS16) eff_col = eff_col >> 1;
      end

      always_comb begin
        slots    = '0;
        slots[0] = '{is_cmd: 1'b1, val: eff_cmd};
        slots[1] = '{is_cmd: 1'b0, val: eff_col[7:0]};
        slots[2] = '{is_cmd: 1'b0, val: eff_col[15:8]};
        slots[3] = '{is_cmd: 1'b0, val: row[7:0]};
        slots[4] = '{is_cmd: 1'b0, val: row[15:8]};
        if (EXTRA_ADDR) begin
          slots[5] = '{is_cmd: 1'b0, val: extra_row};
          slots[6] = '{is_cmd: 1'b1, val: OP_CONFIRM};
        end else begin
          slots[5] = '{is_cmd: 1'b1, val: OP_CONFIRM};
        end
      end
    end else begin : g_small
      // R4: one column byte, command passes unchanged
      always_comb begin
        slots    = '0;
        slots[0] = '{is_cmd: 1'b1, val: cmd};
        slots[1] = '{is_cmd: 1'b0, val: col[7:0]};
        slots[2] = '{is_cmd: 1'b0, val: row[7:0]};
        slots[3] = '{is_cmd: 1'b0, val: row[15:8]};
        if (EXTRA_ADDR) slots[4] = '{is_cmd: 1'b0, val: extra_row};
      end
    end
  endgenerate

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE      = 1'b1,
  parameter bit EXTRA_ADDR      = 1'b1,
  parameter bit BUS16           = 1'b0,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int BLOCK_W         = 14,
  parameter int COL_W           = 12,
  localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [7:0]         cmd_in,
  input  logic [BLOCK_W-1:0] block_in,
  input  logic [PAGE_W-1:0]  page_in,
  input  logic [COL_W-1:0]   col_in,
  input  logic               flash_rdy,
  output logic               flash_cle,
  output logic               flash_ale,
  output logic               flash_we_n,
  output logic [7:0]         flash_io,
  output logic               done
);

  seq_state_t                 state;
  logic [7:0]                 req_cmd;
  logic [BLOCK_W-1:0]         req_blk;
  logic [PAGE_W-1:0]          req_page;
  logic [COL_W-1:0]           req_col;
  logic [ROW_BITS-1:0]        row;
  latch_slot_t [MAX_SLOTS-1:0] slots;
  logic [2:0]                 count;
  logic [2:0]                 idx;
  logic                       last_slot;

  nand_row_calc #(
    .BLOCK_W         (BLOCK_W),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PAGE_W          (PAGE_W)
  ) u_row (
    .blk  (req_blk),
    .page (req_page),
    .row  (row)
  );

  nand_frame_build #(
    .LARGE_PAGE (LARGE_PAGE),
    .EXTRA_ADDR (EXTRA_ADDR),
    .BUS16      (BUS16),
    .COL_W      (COL_W)
  ) u_frame (
    .cmd   (req_cmd),
    .col   (req_col),
    .row   (row),
    .slots (slots),
    .count (count)
  );

  assign last_slot = (idx == count - 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_cmd    <= '0;
      req_blk    <= '0;
      req_page   <= '0;
      req_col    <= '0;
      idx        <= '0;
      flash_cle  <= 1'b0;
      flash_ale  <= 1'b0;
      flash_we_n <= 1'b1;
      flash_io   <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            req_cmd  <= cmd_in;
            req_blk  <= block_in;
            req_page <= page_in;
            req_col  <= col_in;
            state    <= ST_WAIT_PRE;
          end
        end
        ST_WAIT_PRE: begin
          if (flash_rdy) begin
            idx        <= '0;
            flash_cle  <= slots[0].is_cmd;
            flash_ale  <= ~slots[0].is_cmd;
            flash_io   <= slots[0].val;
            flash_we_n <= 1'b0;
            state      <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          flash_we_n <= 1'b1;
          state      <= ST_HOLD;
        end
        ST_HOLD: begin
          if (last_slot) begin
            flash_cle <= 1'b0;
            flash_ale <= 1'b0;
            flash_io  <= '0;
            state     <= ST_WAIT_POST;
          end else begin
            idx        <= idx + 3'd1;
            flash_cle  <= slots[idx + 3'd1].is_cmd;
            flash_ale  <= ~slots[idx + 3'd1].is_cmd;
            flash_io   <= slots[idx + 3'd1].val;
            flash_we_n <= 1'b0;
            state      <= ST_STROBE;
          end
        end
        ST_WAIT_POST: begin
          if (flash_rdy) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: latch enables are exclusive
  a_r3_cle_ale_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(flash_cle && flash_ale));

  // R8: strobe low for one cycle, byte held through the next
  a_r8_strobe_hold: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |=> flash_we_n && $stable(flash_io) && $stable(flash_cle) && $stable(flash_ale));

  // R1: no strobe while the device is busy before the frame
  a_r1_wait_ready: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_PRE && !flash_rdy) |=> flash_we_n);

  // R9: done is a single-cycle pulse with both latch enables released
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_released_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (!flash_cle && !flash_ale && flash_we_n));

  // R5: large-page frame closes with the confirm command
  a_r5_confirm_last: assert property (@(posedge clk) disable iff (rst)
    (LARGE_PAGE && state == ST_HOLD && last_slot) |-> (flash_cle && flash_io == OP_CONFIRM));

  // R10: idle keeps the bus quiet
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (flash_we_n && !flash_cle && !flash_ale));

endmodule

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps

// Device model: records latched bytes, models busy windows, flags protocol slips
module nand_dev_model (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [7:0]  pre_len,
  input  logic [7:0]  post_len,
  input  logic        we_n,
  input  logic        cle,
  input  logic        ale,
  input  logic [7:0]  io,
  input  logic        done,
  output logic        rdy,
  output logic        in_op,
  output logic [79:0] cap,
  output logic [3:0]  cap_n,
  output logic [15:0] viol,
  output logic [15:0] dones
);
  logic       pend, armed, prev_done;
  logic [9:0] last_b;
  int         pre_cnt, post_cnt;

  always @(negedge clk) begin
    if (rst) begin
      rdy = 1'b1; in_op = 1'b0; cap = '0; cap_n = '0; viol = '0; dones = '0;
      pend = 1'b0; armed = 1'b0; prev_done = 1'b0; last_b = '0;
      pre_cnt = 0; post_cnt = 0;
    end else begin
      if (!we_n) begin
        if (!rdy || pend || !in_op) viol = viol + 16'd1;
        if (cap_n < 4'd8) cap[cap_n*10 +: 10] = {cle, ale, io};
        cap_n  = cap_n + 4'd1;
        last_b = {cle, ale, io};
        pend   = 1'b1;
      end else if (pend) begin
        if ({cle, ale, io} != last_b) viol = viol + 16'd1;
        pend = 1'b0;
      end
      if (done) begin
        dones = dones + 16'd1;
        if (prev_done || post_cnt != 0 || !in_op || !armed || cle || ale) viol = viol + 16'd1;
        in_op = 1'b0;
      end
      prev_done = done;
      if (start && !in_op) begin
        in_op = 1'b1; cap_n = '0; cap = '0; armed = 1'b0; pre_cnt = int'(pre_len);
      end else if (pre_cnt > 0) begin
        pre_cnt = pre_cnt - 1;
      end
      if (in_op && cap_n != 0 && !armed && we_n && !pend && !cle && !ale) begin
        armed = 1'b1; post_cnt = int'(post_len);
      end else if (post_cnt > 0) begin
        post_cnt = post_cnt - 1;
      end
      rdy = (pre_cnt == 0) && (post_cnt == 0);
    end
  end
endmodule

module nand_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  cmd = '0;
  logic [13:0] blk = '0;
  logic [5:0]  pg = '0;
  logic [11:0] col = '0;
  logic [7:0]  pre_len = '0;
  logic [7:0]  post_len = '0;

  logic        rdy_w  [4];
  logic        cle_w  [4];
  logic        ale_w  [4];
  logic        we_w   [4];
  logic [7:0]  io_w   [4];
  logic        done_w [4];
  logic        busy_w [4];
  logic [79:0] cap_w  [4];
  logic [3:0]  capn_w [4];
  logic [15:0] viol_w [4];
  logic [15:0] dones_w[4];

  int n_checks = 0;
  int n_bad    = 0;
  int n_ops    = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // config g: bit1 = large page, extra row byte for g=1,3, 16-bit bus for g=2
  for (genvar g = 0; g < 4; g++) begin : gen_cfg
    nand_cmd_seq #(
      .LARGE_PAGE (g >= 2),
      .EXTRA_ADDR (g == 1 || g == 3),
      .BUS16      (g == 2)
    ) u_nand_cmd_seq (
      .clk (clk), .rst (rst), .start (start), .cmd_in (cmd),
      .block_in (blk), .page_in (pg), .col_in (col), .flash_rdy (rdy_w[g]),
      .flash_cle (cle_w[g]), .flash_ale (ale_w[g]), .flash_we_n (we_w[g]),
      .flash_io (io_w[g]), .done (done_w[g])
    );
    nand_dev_model u_dev (
      .clk (clk), .rst (rst), .start (start), .pre_len (pre_len), .post_len (post_len),
      .we_n (we_w[g]), .cle (cle_w[g]), .ale (ale_w[g]), .io (io_w[g]), .done (done_w[g]),
      .rdy (rdy_w[g]), .in_op (busy_w[g]), .cap (cap_w[g]), .cap_n (capn_w[g]),
      .viol (viol_w[g]), .dones (dones_w[g])
    );
  end

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void exp_frame(input bit lg, input bit ex, input bit w16,
                                    input logic [7:0] c, input int b, input int p, input int co,
                                    output logic [79:0] f, output int n);
    int row, cx;
    logic [7:0] cc;
    row = b * 64 + p;
    cc = c; cx = co; f = '0; n = 0;
    if (lg) begin
      if (c == 8'h50) begin cc = 8'h00; cx = co + 2048; end
      if (w16) cx = cx >> 1;
    end
    f[n*10 +: 10] = {2'b10, cc};               n++;
    f[n*10 +: 10] = {2'b01, 8'(cx)};           n++;
    if (lg) begin f[n*10 +: 10] = {2'b01, 8'(cx >> 8)}; n++; end
    f[n*10 +: 10] = {2'b01, 8'(row)};          n++;
    f[n*10 +: 10] = {2'b01, 8'(row >> 8)};     n++;
    if (ex) begin f[n*10 +: 10] = {2'b01, 4'h0, 4'(row >> 16)}; n++; end
    if (lg) begin f[n*10 +: 10] = {2'b10, 8'h30}; n++; end
  endfunction

  task automatic run_op(input logic [7:0] c, input int b, input int p, input int co,
                        input int pre, input int post, input bit restart, input string tag);
    bit all_idle;
    logic [79:0] ef;
    int en;
    @(posedge clk); #2;
    cmd = c; blk = 14'(b); pg = 6'(p); col = 12'(co);
    pre_len = 8'(pre); post_len = 8'(post);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (restart) begin
      // R9: start while a frame is in flight must be ignored
      repeat (3) @(posedge clk);
      #2;
      cmd = ~c; blk = ~blk; pg = ~pg; col = ~col;
      start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
    end
    all_idle = 1'b0;
    for (int t = 0; t < 3000 && !all_idle; t++) begin
      @(negedge clk);
      all_idle = !busy_w[0] && !busy_w[1] && !busy_w[2] && !busy_w[3];
    end
    n_ops++;
    check(all_idle, {tag, " R9 sequence completes"}, 80'(all_idle), 80'd1);
    for (int g = 0; g < 4; g++) begin
      exp_frame(g >= 2, g == 1 || g == 3, g == 2, c, b, p, co, ef, en);
      check(capn_w[g] == 4'(en), $sformatf("%s cfg%0d byte count", tag, g), 80'(capn_w[g]), 80'(en));
      check(cap_w[g] == ef, $sformatf("%s cfg%0d frame", tag, g), cap_w[g], ef);
      check(dones_w[g] == 16'(n_ops), $sformatf("R9 cfg%0d done count", g), 80'(dones_w[g]), 80'(n_ops));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R10: quiet bus after reset
    for (int g = 0; g < 4; g++)
      check(we_w[g] && !cle_w[g] && !ale_w[g] && !done_w[g], $sformatf("R10 cfg%0d reset state", g),
            80'({we_w[g], cle_w[g], ale_w[g], done_w[g]}), 80'(4'b1000));

    // directed corners
    run_op(8'h00, 0, 0, 0, 0, 0, 1'b0, "R4 R5 zero address");
    run_op(8'h00, 16383, 63, 4095, 0, 0, 1'b0, "R2 max row and column");
    run_op(8'h50, 16383, 63, 4095, 3, 2, 1'b0, "R6 spare read max column");
    run_op(8'h50, 5, 7, 1, 0, 0, 1'b0, "R7 spare read odd column");
    run_op(8'h5A, 1234, 33, 2049, 5, 0, 1'b0, "R1 ready late before frame");
    run_op(8'hE0, 77, 12, 300, 0, 5, 1'b0, "R9 ready late after frame");
    run_op(8'h00, 4096, 17, 1000, 1, 1, 1'b1, "R9 start ignored mid frame");
    run_op(8'h50, 8191, 0, 2048, 2, 4, 1'b1, "R6 start ignored mid spare frame");

    // constrained random
    for (int i = 0; i < 40; i++) begin
      logic [7:0] rc;
      int sel;
      sel = int'($urandom % 4);
      rc = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h50 : 8'($urandom);
      run_op(rc, int'($urandom % 16384), int'($urandom % 64), int'($urandom % 4096),
             int'($urandom % 6), int'($urandom % 6), 1'b0, "R3 R4 R5 R8 random");
    end

    // R1 R8 R3: model saw no strobe while busy, no long pulse, no unstable byte
    for (int g = 0; g < 4; g++)
      check(viol_w[g] == 16'd0, $sformatf("R1 R3 R8 cfg%0d protocol slips", g), 80'(viol_w[g]), 80'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule